// File: doc/BRIEF.md
# Edge-Counting Microsecond Timestamp Counter

This block turns a square-wave reference signal into a microsecond timestamp that does not depend on the frequency of the system clock. Each rising and each falling edge of the reference adds one count, so a reference toggling at half the tick rate yields one count per microsecond. A narrow edge counter runs from zero up to one below a programmable limit and then wraps. Each wrap raises a pending limit event. When software services that event, a fixed number of milliseconds is added to a wide millisecond accumulator, and the pending bit is cleared in the same clock cycle.

A read request returns a 64-bit timestamp one cycle later. All state is sampled on a single clock edge: the millisecond accumulator scaled by the ticks per millisecond, plus the live edge count, plus one extra period when a limit event is pending and not yet serviced. A wrap that happens around a read is therefore neither lost nor counted twice. The block has start, stop and clear commands, an interrupt enable and a write-one-to-clear pulse for the status.

Top module: `edge_timestamp`

## Requirements
- R1: While running, every rising and every falling edge of `refIn` adds exactly one to the edge count. The count changes on the third rising clock edge after `refIn` changes (two synchroniser flops plus the count register).
- R2: The edge count never reaches `HIGH_LIMIT`. An edge that would take it there sets it to zero and sets the pending status. A wrap sets the status even in a cycle in which `irqClear` or `svcEvent` is asserted.
- R3: `svcEvent` while the status is pending adds `PERIOD_MS` to the millisecond accumulator and clears the status in the same cycle. `svcEvent` with no status pending changes nothing.
- R4: The level of `ctrlIn` has no effect. The count always increments.
- R5: `readReq` produces `readValid` high for one cycle on the next clock. `readStamp` then equals `US_PER_MS * ms + count`, with both values taken at the request edge, and holds until the next read.
- R6: If the status is pending at the request edge, the stamp uses `ms + PERIOD_MS` in place of `ms`.
- R7: `startCmd` zeroes the count, the accumulator and the status, and counting begins from the next cycle. It has priority over every other command in the same cycle.
- R8: After `stopCmd` the count is frozen and edges are ignored until the next start.
- R9: `clearCmd` zeroes the count and the status, leaves the accumulator alone and does not change the running state.
- R10: `irqOut` is high exactly when the status is pending and `irqEnable` is high. An `irqClear` pulse clears the status without changing the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Asynchronous square-wave reference |
| ctrlIn | input | 1 | Control level; has no effect on counting |
| startCmd | input | 1 | Pulse: clear all state and begin counting |
| stopCmd | input | 1 | Pulse: freeze the count |
| clearCmd | input | 1 | Pulse: zero the count and the pending status |
| irqEnable | input | 1 | Level: lets the pending status reach `irqOut` |
| irqClear | input | 1 | Pulse: write-one-to-clear of the pending status |
| svcEvent | input | 1 | Pulse: service a pending event (add period, clear status) |
| readReq | input | 1 | Pulse: capture a timestamp |
| readValid | output | 1 | One-cycle strobe: `readStamp` was updated |
| readStamp | output | 64 | Captured microsecond timestamp |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the count step and the wrap to zero, that a wrap always leaves the status set, the accumulator arithmetic on service and on start, and that service, clear and read strobes have their effect one cycle later. Whether the stamp correctly combines the accumulator, the count and a pending period, that `ctrlIn` is ignored, and that a stopped counter ignores real reference edges coming through the synchroniser can only be seen in the bench's scenarios. There, a behavioural model is compared cycle by cycle against the stamp and the interrupt.

// File: rtl/edge_ts_pkg.sv
package edge_ts_pkg;

  // Strobes from the control unit to the datapath, valid for one cycle.
  typedef struct packed {
    logic clrCount;    // zero the edge counter
    logic clrAccum;    // zero the millisecond accumulator
    logic countEn;     // a qualified reference edge to count
    logic addPeriod;   // add one period to the accumulator
    logic sampleStamp; // capture the timestamp register
    logic addOne;      // include one pending period in the capture
  } dpStrobes_t;

endpackage

// File: rtl/edge_ts_sync.sv
module edge_ts_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic edgePulse
);

  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  // Any change of the synchronised level is one edge, rising or falling.
  assign edgePulse = chain[CHAIN_LEN-1] ^ chain[CHAIN_LEN-2];

endmodule

// File: rtl/edge_ts_ctrl.sv
module edge_ts_ctrl
  import edge_ts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edgePulse,
  input  logic       ctrlIn,
  input  logic       startCmd,
  input  logic       stopCmd,
  input  logic       clearCmd,
  input  logic       irqEnable,
  input  logic       irqClear,
  input  logic       svcEvent,
  input  logic       readReq,
  input  logic       wrapHit,
  output dpStrobes_t strobes,
  output logic       readValid,
  output logic       irqOut
);

  logic running;
  logic pending;

  // The control level is accepted but deliberately plays no part (R4).
  logic unusedCtrlLevel;
  assign unusedCtrlLevel = ctrlIn;

  always_comb begin
    strobes             = '0;
    strobes.clrCount    = startCmd | clearCmd;
    strobes.clrAccum    = startCmd;
    strobes.countEn     = running & edgePulse & ~startCmd & ~stopCmd & ~clearCmd;
    strobes.addPeriod   = svcEvent & pending & ~startCmd;
    strobes.sampleStamp = readReq;
    strobes.addOne      = pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
    end else if (startCmd) begin
      running <= 1'b1;
    end else if (stopCmd) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (startCmd || clearCmd) begin
      pending <= 1'b0;
    end else if (wrapHit) begin
      pending <= 1'b1;
    end else if (irqClear || svcEvent) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readValid <= 1'b0;
    else        readValid <= readReq;
  end

  assign irqOut = pending & irqEnable;

  p_wrap_sets_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrapHit |=> pending);

  p_service_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (svcEvent && !wrapHit) |=> !pending);

  p_read_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    readReq |=> readValid);

  p_stop_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stopCmd && !startCmd) |=> !strobes.countEn || $past(startCmd));

  p_clear_drops_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clearCmd |=> !pending);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqClear && !wrapHit) |=> !irqOut);

endmodule

// File: rtl/edge_ts_datapath.sv
module edge_ts_datapath
  import edge_ts_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MS_W       = 32,
  parameter int STAMP_W    = 64,
  parameter int HIGH_LIMIT = 30000,
  parameter int PERIOD_MS  = 30,
  parameter int US_PER_MS  = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobes_t         strobes,
  output logic               wrapHit,
  output logic [STAMP_W-1:0] readStamp
);

  localparam logic [CNT_W-1:0]   LAST_COUNT = CNT_W'(HIGH_LIMIT - 1);
  localparam logic [MS_W-1:0]    PERIOD_INC = MS_W'(PERIOD_MS);
  localparam logic [STAMP_W-1:0] PERIOD_WIDE = STAMP_W'(PERIOD_MS);
  localparam logic [STAMP_W-1:0] SCALE = STAMP_W'(US_PER_MS);

  logic [CNT_W-1:0]   edgeCount;
  logic [MS_W-1:0]    msAccum;
  logic [STAMP_W-1:0] msTotal;

  assign wrapHit = strobes.countEn && (edgeCount == LAST_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edgeCount <= '0;
    end else if (strobes.clrCount) begin
      edgeCount <= '0;
    end else if (wrapHit) begin
      edgeCount <= '0;
    end else if (strobes.countEn) begin
      edgeCount <= edgeCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msAccum <= '0;
    end else if (strobes.clrAccum) begin
      msAccum <= '0;
    end else if (strobes.addPeriod) begin
      msAccum <= msAccum + PERIOD_INC;
    end
  end

  // A pending wrap stands for one period that has not yet reached the accumulator.
  assign msTotal = STAMP_W'(msAccum) + (strobes.addOne ? PERIOD_WIDE : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readStamp <= '0;
    end else if (strobes.sampleStamp) begin
      readStamp <= msTotal * SCALE + STAMP_W'(edgeCount);
    end
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.countEn && !strobes.clrCount && edgeCount != LAST_COUNT)
      |=> edgeCount == $past(edgeCount) + 1'b1);

  p_count_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edgeCount <= LAST_COUNT);

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrapHit |=> edgeCount == '0);

  p_service_adds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.addPeriod && !strobes.clrAccum) |=> msAccum == $past(msAccum) + PERIOD_INC);

  p_start_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrAccum |=> (msAccum == '0 && edgeCount == '0));

  p_accum_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.addPeriod && !strobes.clrAccum) |=> $stable(msAccum));

  p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.countEn && !strobes.clrCount) |=> $stable(edgeCount));

endmodule

// File: rtl/edge_timestamp.sv
module edge_timestamp
  import edge_ts_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MS_W        = 32,
  parameter int HIGH_LIMIT  = 30000,
  parameter int PERIOD_MS   = 30,
  parameter int US_PER_MS   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        refIn,
  input  logic        ctrlIn,
  input  logic        startCmd,
  input  logic        stopCmd,
  input  logic        clearCmd,
  input  logic        irqEnable,
  input  logic        irqClear,
  input  logic        svcEvent,
  input  logic        readReq,
  output logic        readValid,
  output logic [63:0] readStamp,
  output logic        irqOut
);

  localparam int STAMP_W = 64;

  logic       edgePulse;
  logic       wrapHit;
  dpStrobes_t strobes;

  edge_ts_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .asyncIn  (refIn),
    .edgePulse(edgePulse)
  );

  edge_ts_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .edgePulse(edgePulse),
    .ctrlIn   (ctrlIn),
    .startCmd (startCmd),
    .stopCmd  (stopCmd),
    .clearCmd (clearCmd),
    .irqEnable(irqEnable),
    .irqClear (irqClear),
    .svcEvent (svcEvent),
    .readReq  (readReq),
    .wrapHit  (wrapHit),
    .strobes  (strobes),
    .readValid(readValid),
    .irqOut   (irqOut)
  );

  edge_ts_datapath #(
    .CNT_W     (CNT_W),
    .MS_W      (MS_W),
    .STAMP_W   (STAMP_W),
    .HIGH_LIMIT(HIGH_LIMIT),
    .PERIOD_MS (PERIOD_MS),
    .US_PER_MS (US_PER_MS)
  ) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .wrapHit  (wrapHit),
    .readStamp(readStamp)
  );

endmodule

// File: tb/test_edge_timestamp.sv
module test_edge_timestamp;

  localparam int LIMIT  = 20;
  localparam int PERIOD = 2;
  localparam int SCALE  = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refIn = 1'b0;
  logic        ctrlIn = 1'b0;
  logic        startCmd = 1'b0;
  logic        stopCmd = 1'b0;
  logic        clearCmd = 1'b0;
  logic        irqEnable = 1'b0;
  logic        irqClear = 1'b0;
  logic        svcEvent = 1'b0;
  logic        readReq = 1'b0;
  logic        readValid;
  logic [63:0] readStamp;
  logic        irqOut;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string curTag = "R7";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  edge_timestamp #(
    .HIGH_LIMIT(LIMIT),
    .PERIOD_MS (PERIOD),
    .US_PER_MS (SCALE)
  ) i_edge_timestamp (
    .clk      (clk),
    .rst_n    (rst_n),
    .refIn    (refIn),
    .ctrlIn   (ctrlIn),
    .startCmd (startCmd),
    .stopCmd  (stopCmd),
    .clearCmd (clearCmd),
    .irqEnable(irqEnable),
    .irqClear (irqClear),
    .svcEvent (svcEvent),
    .readReq  (readReq),
    .readValid(readValid),
    .readStamp(readStamp),
    .irqOut   (irqOut)
  );

  // Behavioural reference model.
  bit     mRun, mPend, mValid;
  longint mCnt, mMs, mStamp;
  bit     hist[$] = '{1'b0, 1'b0, 1'b0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mRun = 0; mPend = 0; mValid = 0; mCnt = 0; mMs = 0; mStamp = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit     edgeSeen, wrap, oldPend;
      longint oldCnt, oldMs;
      edgeSeen = (hist[1] != hist[2]);
      hist.push_front(refIn);
      void'(hist.pop_back());
      oldPend = mPend; oldCnt = mCnt; oldMs = mMs;
      wrap = 0;
      mValid = readReq;
      if (readReq) mStamp = SCALE * (oldMs + (oldPend ? PERIOD : 0)) + oldCnt;
      if (startCmd) begin
        mRun = 1; mCnt = 0; mMs = 0; mPend = 0;
      end else begin
        if (stopCmd) mRun = 0;
        if (clearCmd) begin
          mCnt = 0;
        end else if (mRun && edgeSeen) begin
          if (mCnt == LIMIT - 1) begin mCnt = 0; wrap = 1; end
          else mCnt = mCnt + 1;
        end
        if (svcEvent && oldPend) mMs = (mMs + PERIOD) & 64'hFFFF_FFFF;
        if (clearCmd) mPend = 0;
        else if (wrap) mPend = 1;
        else if (irqClear || svcEvent) mPend = 0;
      end
    end
  end

  task automatic check(string tag, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(curTag, longint'(readValid), longint'(mValid), "readValid");
      check("R10", longint'(irqOut), longint'(mPend && irqEnable), "irqOut");
      check(curTag, longint'(readStamp), mStamp, "readStamp");
    end
  end

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) refIn = ~refIn;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic readExpect(string tag, longint exp);
    @(negedge clk) readReq = 1'b1;
    @(negedge clk) readReq = 1'b0;
    check(tag, longint'(readValid), 1, "readValid after request");
    check(tag, longint'(readStamp), exp, "stamp");
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG_CYCLES && !done) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    curTag = "R7";
    check("R7", longint'(readValid), 0, "readValid in reset");
    check("R7", longint'(irqOut), 0, "irqOut in reset");
    @(negedge clk) rst_n = 1'b1;

    curTag = "R8";
    edges(3);
    readExpect("R8", 0);

    curTag = "R1";
    pulse(startCmd);
    fork
      edges(5);
      begin
        for (int k = 0; k < 6; k++) begin
          @(negedge clk) ctrlIn = ~ctrlIn;
          repeat (2) @(negedge clk);
        end
      end
    join
    readExpect("R1", 5);
    check("R4", longint'(readStamp), 5, "count with ctrlIn toggling");

    curTag = "R2";
    edges(20);
    check("R2", longint'(irqOut), 0, "irqOut masked");
    @(negedge clk) irqEnable = 1'b1;
    @(negedge clk);
    check("R10", longint'(irqOut), 1, "irqOut enabled pending");
    curTag = "R6";
    readExpect("R6", 25);

    curTag = "R3";
    pulse(svcEvent);
    check("R3", longint'(irqOut), 0, "status cleared by service");
    readExpect("R3", 25);
    pulse(svcEvent);
    readExpect("R3", 25);

    curTag = "R10";
    edges(17);
    check("R2", longint'(irqOut), 1, "second wrap pending");
    pulse(irqClear);
    check("R10", longint'(irqOut), 0, "status cleared by irqClear");
    readExpect("R10", 22);

    curTag = "R8";
    pulse(stopCmd);
    edges(6);
    readExpect("R8", 22);

    curTag = "R7";
    pulse(startCmd);
    readExpect("R7", 0);
    edges(7);
    readExpect("R5", 7);

    curTag = "R9";
    edges(13);
    pulse(clearCmd);
    check("R9", longint'(irqOut), 0, "clear drops status");
    readExpect("R9", 0);
    edges(3);
    readExpect("R9", 3);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule